// File: doc/BRIEF.md
# Binary-Field Montgomery Inverter

This block computes the inverse of a nonzero element of GF(2^M) in the Montgomery domain, with the field polynomial supplied per request. An element enters as an M-bit coefficient vector together with an (M+1)-bit field polynomial. The block runs a fixed schedule of exactly 2M iteration steps, one per clock, and then returns `a^-1 · x^(2M) mod p`. When `a` is already in Montgomery form (`a·x^M`), the result is the Montgomery form of its inverse (`a^-1·x^M`).

Each step works on two polynomial registers, one of which is always odd: the fixed operand. The other is the working operand. The working operand is either halved, or replaced by the halved sum of the two. When a signed balance counter is positive, the roles of the two registers are exchanged. No polynomial degrees are ever compared. Two coefficient registers follow the same moves, and each is doubled modulo p through a shift and a conditional XOR.

The request side is a valid/ready port. `in_ready` is high only while the block is idle. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. While busy, `in_ready` is low and the input pins are not looked at, so a held request simply waits. The result side has no back-pressure: `out_valid` pulses for one cycle, and `out_r` keeps its value until the next request is accepted.

Top module: `gf2m_mont_inv`

## Requirements
- R1: After reset, `in_ready` is 1, `out_valid` is 0 and `out_r` is 0.
- R2: A request is taken on a rising edge where `in_valid` and `in_ready` are both 1. From that edge until the cycle in which `out_valid` is high, `in_ready` is 0.
- R3: `out_valid` is high for exactly one cycle. That cycle starts 2M+1 rising edges after the accepting edge, counting the accepting edge as the first.
- R4: In the cycle `out_valid` is high, `out_r` satisfies `out_r · a ≡ x^(2M) (mod p)`. Here bit i of `in_a`, `in_p` and `out_r` is the coefficient of x^i, and `out_r` is fully reduced (degree below M).
- R5: `in_valid`, `in_a` and `in_p` have no effect while a computation is in progress. The polynomial and operand captured at the accepting edge are used throughout, whatever the pins do later.
- R6: `out_r` does not change from the `out_valid` cycle until the clock edge that accepts the next request.
- R7: A request presented in the `out_valid` cycle is accepted at the very next edge. Its result obeys R3 and R4.
- R8: During a computation the fixed operand stays odd and the balance counter stays within -2M..2M+1. At the end, the fixed operand equals 1 and the working operand equals 0. This holds for `in_p` with bits M and 0 set and irreducible, and for `in_a` nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Block idle and able to take a request |
| in_a | input | M | Operand, bit i = coefficient of x^i, must be nonzero |
| in_p | input | M+1 | Irreducible field polynomial, bits M and 0 set |
| out_valid | output | 1 | One-cycle pulse: result available |
| out_r | output | M | Montgomery-domain inverse, held until next accept |

## Verification
The hardest cases to reach from the ports are the balance-counter corners. One is a tie at zero, which makes the block merge into the working register rather than swap. The other is a run that finishes with the fixed operand in the second register, so that the result must come from the second coefficient lane. Neither can be forced directly. They are reached by sweeping every nonzero operand under several field polynomials, which drives the counter through all the sign changes a small field allows. The result of each run is compared with an inverse that the bench finds by brute-force search. Separate runs change the pins while the block is busy, hold a request across the completion cycle, and leave the block idle after a result.

// File: rtl/gf2inv_pkg.sv
package gf2inv_pkg;

  // Step selected by the controller for one clock.
  typedef enum logic [2:0] {
    OP_IDLE  = 3'd0,  // hold all registers
    OP_LOAD  = 3'd1,  // capture a new request
    OP_HALVE = 3'd2,  // working operand even: divide it by x
    OP_MERGE = 3'd3,  // both odd, balance <= 0: working <- (u^v)/x
    OP_SWAP  = 3'd4   // both odd, balance > 0: fixed <- (u^v)/x, roles exchange
  } inv_op_e;

endpackage

// File: rtl/gf2inv_dbl.sv
// Multiply a reduced element by x modulo the field polynomial.
module gf2inv_dbl #(
  parameter int M = 8
) (
  input  logic [M-1:0] c_in,
  input  logic [M-1:0] p_low,
  output logic [M-1:0] c_out
);

  logic [M-1:0] shifted;
  logic [M-1:0] fold;

  assign shifted = {c_in[M-2:0], 1'b0};
  assign fold    = c_in[M-1] ? p_low : '0;
  assign c_out   = shifted ^ fold;

endmodule

// File: rtl/gf2inv_ctrl.sv
// Iteration schedule, balance counter and role bit.
module gf2inv_ctrl
  import gf2inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    g_lsb,
  output logic    in_ready,
  output logic    busy,
  output logic    gsel,
  output inv_op_e op,
  output logic    out_valid
);

  localparam int IW     = $clog2(2 * M + 1);
  localparam int DW     = $clog2(2 * M + 2) + 1;
  localparam int LAST   = 2 * M - 1;
  localparam int DMAX_I = 2 * M + 1;
  localparam int DMIN_I = -2 * M;
  localparam logic signed [DW-1:0] ONE  = DW'(1);
  localparam logic signed [DW-1:0] ZERO = '0;

  logic                 busy_q;
  logic                 gsel_q;
  logic                 done_q;
  logic [IW-1:0]        iter_q;
  logic signed [DW-1:0] delta_q;
  logic                 accept;
  logic                 last_iter;

  assign in_ready  = !busy_q;
  assign busy      = busy_q;
  assign gsel      = gsel_q;
  assign out_valid = done_q;
  assign accept    = in_valid && !busy_q;
  assign last_iter = (iter_q == IW'(LAST));

  always_comb begin
    op = OP_IDLE;
    if (accept) begin
      op = OP_LOAD;
    end else if (busy_q) begin
      if (!g_lsb) begin
        op = OP_HALVE;
      end else if (delta_q > ZERO) begin
        op = OP_SWAP;
      end else begin
        op = OP_MERGE;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      gsel_q  <= 1'b0;
      done_q  <= 1'b0;
      iter_q  <= '0;
      delta_q <= '0;
    end else begin
      done_q <= busy_q && last_iter;
      case (op)
        OP_LOAD: begin
          busy_q  <= 1'b1;
          gsel_q  <= 1'b0;
          iter_q  <= '0;
          delta_q <= ONE;
        end
        OP_HALVE, OP_MERGE: begin
          delta_q <= delta_q + ONE;
        end
        OP_SWAP: begin
          delta_q <= ONE - delta_q;
          gsel_q  <= ~gsel_q;
        end
        default: ;
      endcase
      if (busy_q) begin
        iter_q <= iter_q + IW'(1);
        if (last_iter) busy_q <= 1'b0;
      end
    end
  end

  // R8: balance counter never leaves its bounded range
  assert_delta_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (int'(delta_q) <= DMAX_I && int'(delta_q) >= DMIN_I));

  // R3: completion is a single-cycle pulse that follows a busy cycle
  assert_done_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_done_after_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($past(busy_q) && !busy_q));

endmodule

// File: rtl/gf2inv_uv_path.sv
// The two operand registers; lane 0 starts with p, lane 1 with a.
module gf2inv_uv_path
  import gf2inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  inv_op_e      op,
  input  logic         gsel,
  input  logic         busy,
  input  logic         done,
  input  logic [M-1:0] in_a,
  input  logic [M:0]   in_p,
  output logic [M-1:0] p_low,
  output logic         g_lsb
);

  logic [M:0]   x_w [2];
  logic [M:0]   mix_w;
  logic [M-1:0] pl_q;
  logic [M:0]   f_w;
  logic [M:0]   g_w;

  // Lane gsel holds the fixed operand, the other lane the working one.
  assign f_w   = gsel ? x_w[1] : x_w[0];
  assign g_w   = gsel ? x_w[0] : x_w[1];
  assign g_lsb = g_w[0];
  assign mix_w = (x_w[0] ^ x_w[1]) >> 1;
  assign p_low = pl_q;

  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    localparam logic LANE = 1'(gi);
    logic [M:0] val_q;
    logic [M:0] val_d;
    logic       is_f;

    assign is_f = (gsel == LANE);

    always_comb begin
      val_d = val_q;
      case (op)
        OP_LOAD:  val_d = (gi == 0) ? in_p : {1'b0, in_a};
        OP_HALVE: if (!is_f) val_d = val_q >> 1;
        OP_MERGE: if (!is_f) val_d = mix_w;
        OP_SWAP:  if (is_f)  val_d = mix_w;
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign x_w[gi] = val_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pl_q <= '0;
    else if (op == OP_LOAD)  pl_q <= in_p[M-1:0];
  end

  // R8: the fixed operand is odd for the whole computation
  assert_fixed_odd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> f_w[0]);

  // R8: at completion the fixed operand is 1 and the working operand 0
  assert_converged_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (f_w == (M+1)'(1) && g_w == '0));

endmodule

// File: rtl/gf2inv_coef_path.sv
// Coefficient registers tracking the operands; lane 0 pairs with lane 0 above.
module gf2inv_coef_path
  import gf2inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  inv_op_e      op,
  input  logic         gsel,
  input  logic [M-1:0] p_low,
  output logic [M-1:0] res
);

  logic [M-1:0] c_w [2];

  // The coefficient of the fixed operand is the answer once it equals 1.
  assign res = gsel ? c_w[1] : c_w[0];

  for (genvar gi = 0; gi < 2; gi++) begin : g_lane
    localparam logic LANE = 1'(gi);
    logic [M-1:0] val_q;
    logic [M-1:0] val_d;
    logic [M-1:0] twice;
    logic [M-1:0] sum;
    logic         is_f;

    assign is_f = (gsel == LANE);
    assign sum  = val_q ^ c_w[1-gi];

    gf2inv_dbl #(.M(M)) dbl_i (
      .c_in  (val_q),
      .p_low (p_low),
      .c_out (twice)
    );

    always_comb begin
      val_d = val_q;
      case (op)
        OP_LOAD:  val_d = (gi == 0) ? '0 : M'(1);
        OP_HALVE: if (is_f) val_d = twice;
        OP_MERGE: val_d = is_f ? twice : sum;
        OP_SWAP:  val_d = is_f ? sum : twice;
        default: ;
      endcase
    end

    always_ff @(posedge clk) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
    end

    assign c_w[gi] = val_q;
  end

endmodule

// File: rtl/gf2m_mont_inv.sv
module gf2m_mont_inv
  import gf2inv_pkg::*;
#(
  parameter int M = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [M-1:0] in_a,
  input  logic [M:0]   in_p,
  output logic         out_valid,
  output logic [M-1:0] out_r
);

  inv_op_e      op;
  logic         gsel;
  logic         busy;
  logic         g_lsb;
  logic [M-1:0] p_low;

  gf2inv_ctrl #(.M(M)) ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .g_lsb     (g_lsb),
    .in_ready  (in_ready),
    .busy      (busy),
    .gsel      (gsel),
    .op        (op),
    .out_valid (out_valid)
  );

  gf2inv_uv_path #(.M(M)) uv_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .gsel  (gsel),
    .busy  (busy),
    .done  (out_valid),
    .in_a  (in_a),
    .in_p  (in_p),
    .p_low (p_low),
    .g_lsb (g_lsb)
  );

  gf2inv_coef_path #(.M(M)) coef_i (
    .clk   (clk),
    .rst_n (rst_n),
    .op    (op),
    .gsel  (gsel),
    .p_low (p_low),
    .res   (out_r)
  );

  // R6: with no computation running and no request taken, the result holds
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(in_valid && in_ready)) |=> $stable(out_r));

  // R2: the block is never ready while computing
  assert_busy_not_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> (!in_ready && !out_valid));

endmodule

// File: tb/gf2m_mont_inv_tb.sv
module gf2m_mont_inv_tb_top;

  localparam int M   = 8;
  localparam int LAT = 2 * M + 1;

  logic         clk;
  logic         rst_n;
  logic         in_valid;
  logic         in_ready;
  logic [M-1:0] in_a;
  logic [M:0]   in_p;
  logic         out_valid;
  logic [M-1:0] out_r;

  int n_tests = 0;
  int n_fail  = 0;

  gf2m_mont_inv #(.M(M)) dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_a      (in_a),
    .in_p      (in_p),
    .out_valid (out_valid),
    .out_r     (out_r)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  function automatic logic [M-1:0] times_x(input logic [M-1:0] v, input logic [M:0] p);
    logic [M-1:0] t;
    t = v << 1;
    if (v[M-1]) t = t ^ p[M-1:0];
    return t;
  endfunction

  function automatic logic [M-1:0] gmul(input logic [M-1:0] a, input logic [M-1:0] b,
                                        input logic [M:0] p);
    logic [M-1:0] acc;
    acc = '0;
    for (int i = M - 1; i >= 0; i--) begin
      acc = times_x(acc, p);
      if (b[i]) acc = acc ^ a;
    end
    return acc;
  endfunction

  function automatic logic [M-1:0] target(input logic [M:0] p);
    logic [M-1:0] t;
    t = M'(1);
    for (int i = 0; i < 2 * M; i++) t = times_x(t, p);
    return t;
  endfunction

  // Brute-force: the unique b with b*a = x^(2M) mod p.
  function automatic logic [M-1:0] expect_inv(input logic [M-1:0] a, input logic [M:0] p);
    logic [M-1:0] tg;
    tg = target(p);
    for (int b = 0; b < (1 << M); b++) begin
      if (gmul(a, M'(b), p) == tg) return M'(b);
    end
    return '0;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Present one request and wait for its result; lat counts edges from acceptance.
  task automatic run_req(input logic [M-1:0] a, input logic [M:0] p,
                         output logic [M-1:0] r, output int lat);
    @(negedge clk);
    in_a     = a;
    in_p     = p;
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    lat = 1;
    while (!out_valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    r = out_r;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL R3 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [M:0]   polys [3];
    logic [M-1:0] r;
    logic [M-1:0] held;
    logic [M-1:0] exp_v;
    int           lat;

    polys[0] = 9'h11B;
    polys[1] = 9'h11D;
    polys[2] = 9'h12B;

    rst_n    = 1'b0;
    in_valid = 1'b0;
    in_a     = '0;
    in_p     = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(in_ready == 1'b1, "R1 in_ready after reset", int'(in_ready), 1);
    check(out_valid == 1'b0, "R1 out_valid after reset", int'(out_valid), 0);
    check(out_r == '0, "R1 out_r after reset", int'(out_r), 0);

    // Exhaustive sweep: every nonzero operand under each polynomial (R3, R4, R8).
    for (int pi = 0; pi < 3; pi++) begin
      for (int av = 1; av < (1 << M); av++) begin
        run_req(M'(av), polys[pi], r, lat);
        exp_v = expect_inv(M'(av), polys[pi]);
        check(lat == LAT, "R3 latency", lat, LAT);
        check(r == exp_v, "R4 R8 inverse", int'(r), int'(exp_v));
      end
    end

    // R2 / R5: pins toggle during a computation and must be ignored.
    @(negedge clk);
    in_a     = 8'h53;
    in_p     = polys[0];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 not ready while busy", int'(in_ready), 0);
    lat = 1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      lat++;
      in_valid = 1'b1;
      in_a     = 8'hCA;
      in_p     = polys[1];
    end
    check(in_ready == 1'b0, "R2 still busy", int'(in_ready), 0);
    @(negedge clk);
    lat++;
    in_valid = 1'b0;
    in_p     = 9'h1FF;
    while (!out_valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    exp_v = expect_inv(8'h53, polys[0]);
    check(lat == LAT, "R5 latency unchanged by busy pins", lat, LAT);
    check(out_r == exp_v, "R5 busy pins ignored", int'(out_r), int'(exp_v));
    check(in_ready == 1'b1, "R2 ready in completion cycle", int'(in_ready), 1);

    // R6 / R3: idle period after a result; value held, no second pulse.
    held = out_r;
    in_a = 8'h01;
    in_p = polys[2];
    for (int k = 0; k < 6; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R3 single pulse", int'(out_valid), 0);
      check(out_r == held, "R6 result held", int'(out_r), int'(held));
    end

    // R7: request held high across the completion cycle.
    @(negedge clk);
    in_a     = 8'h02;
    in_p     = polys[1];
    in_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    in_a = 8'hFF;
    in_p = polys[2];
    lat = 1;
    while (!out_valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    exp_v = expect_inv(8'h02, polys[1]);
    check(out_r == exp_v, "R7 first of back-to-back", int'(out_r), int'(exp_v));
    check(in_ready == 1'b1, "R7 ready at completion", int'(in_ready), 1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R7 second request taken", int'(in_ready), 0);
    lat = 1;
    while (!out_valid && lat < 4 * LAT) begin
      @(negedge clk);
      lat++;
    end
    exp_v = expect_inv(8'hFF, polys[2]);
    check(lat == LAT, "R7 second latency", lat, LAT);
    check(out_r == exp_v, "R7 second result", int'(out_r), int'(exp_v));

    // R4 corner: a = 1 gives x^(2M) mod p directly.
    run_req(8'h01, polys[0], r, lat);
    exp_v = target(polys[0]);
    check(r == exp_v, "R4 unit operand", int'(r), int'(exp_v));

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule